// File: doc/BRIEF.md
# Shared management bus window bridge

This block is the management-side front end of a switch device that shares a serial management bus with other devices. It receives transactions that have already been decoded from the bus (target address, register number, direction and 16-bit write data) and answers each one with a single response pulse. Internally it drives a request/acknowledge register port that reaches the device's internal functions.

Address strap pins, sampled while reset is held, choose one of three modes. In flat mode the block answers all 32 bus addresses and forwards each access straight to the internal function with the same number. In half-space mode it answers a 16-address window whose base is set by the top strap pin, so two devices can share the bus. In windowed mode it answers only at its strapped even address and only at two registers: a command register and a data register. Software launches internal accesses through these two registers and watches a busy flag.

Top module: `smi_window_bridge`

## Requirements
- R1: While `rst` is high and in the first cycle after it falls, `rsp_valid` and `ib_req` are 0. The busy flag is 0 and the data register holds 0, so a windowed read of either register returns 16'h0000.
- R2: The mode is fixed from the straps sampled while `rst` is high. `strap_split`=1 selects half-space mode. Otherwise `strap_addr`=0 selects flat mode and any other value selects windowed mode. Changing the straps after reset has no effect until the next reset.
- R3: In flat mode every access to address A, register G starts one internal access with device A, register G, the same direction and the write data. A read returns the internal read data.
- R4: In half-space mode the block owns addresses whose bit 4 equals `strap_addr[3]`. An owned access goes to internal device `{1'b0, A[3:0]}`. An access to any other address makes no internal access, and a read of it returns 16'hFFFF.
- R5: In windowed mode the block owns only address `{strap_addr,1'b0}` at register 0 (command) and register 1 (data). Any other address or register makes no internal access, and a read of it returns 16'hFFFF.
- R6: The command word uses these fields: bit 15 is go/busy, bit 12 is the format bit (must be 1), bits 11:10 are the opcode (01 write, 10 read), bits 9:5 are the device and bits 4:0 are the register. A command write with bit 15 set, bit 12 set and a legal opcode sets busy and makes exactly one internal access to the stored device and register.
- R7: A windowed write access presents the data register contents on `ib_wdata` with `ib_write`=1.
- R8: When the internal access of a windowed read is acknowledged, busy clears at that same edge and the data register takes `ib_rdata`.
- R9: A command write whose format bit is 0, or whose opcode is 00 or 11, or whose bit 15 is 0, stores the device and register fields. It never sets busy and makes no internal access.
- R10: While busy is 1, command writes and data writes are ignored. This includes a write made in the acknowledge cycle itself.
- R11: A command read returns busy in bit 15, the stored device in bits 9:5 and the stored register in bits 4:0, with all other bits 0. Every windowed response reflects the state before the edge that captures the request.
- R12: Each request yields one `rsp_valid` pulse, one cycle wide. In windowed mode, and for unowned addresses, the pulse comes in the cycle after the request. In the forwarding modes it comes in the cycle after the acknowledge.
- R13: `ib_req` stays high, with its device, register, direction and data stable, until the cycle in which `ib_ack` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset; straps sampled while high |
| strap_addr | input | 4 | Strapped bus address bits 4:1 |
| strap_split | input | 1 | Strap selecting half-space mode |
| req_valid | input | 1 | One-cycle pulse for a decoded bus transaction |
| req_write | input | 1 | 1 write, 0 read |
| req_phy | input | 5 | Bus target address |
| req_reg | input | 5 | Register number |
| req_wdata | input | 16 | Write data |
| rsp_valid | output | 1 | One-cycle completion pulse |
| rsp_rdata | output | 16 | Read data, valid with rsp_valid |
| ib_req | output | 1 | Internal access request, held until acknowledged |
| ib_write | output | 1 | Internal access direction |
| ib_dev | output | 5 | Internal device number |
| ib_reg | output | 5 | Internal register number |
| ib_wdata | output | 16 | Internal write data |
| ib_ack | input | 1 | Internal access acknowledge, one cycle |
| ib_rdata | input | 16 | Internal read data, valid with ib_ack |

## Verification
In windowed mode a host access to the window and the completion of the internal access can land on the same clock edge. The bench provokes this by holding back the acknowledge by hand and raising it in the same cycle as a command read, and later in the same cycle as a command write. The read must still report busy with the old fields, and the data register must then hold the acknowledged value. The colliding command write must be dropped, so a later command read shows the earlier fields with busy clear.

// File: rtl/smi_win_pkg.sv
package smi_win_pkg;
  typedef enum logic [1:0] {
    MODE_FLAT  = 2'd0,
    MODE_HALF  = 2'd1,
    MODE_WIN   = 2'd2
  } mode_e;

  localparam int CMD_GO_BIT  = 15;
  localparam int CMD_FMT_BIT = 12;
  localparam int CMD_OP_LO   = 10;
  localparam int CMD_DEV_LO  = 5;
  localparam int CMD_REG_LO  = 0;

  localparam logic [1:0] OP_WRITE = 2'b01;
  localparam logic [1:0] OP_READ  = 2'b10;
endpackage

// File: rtl/smi_strap_decode.sv
module smi_strap_decode
  import smi_win_pkg::*;
#(
  parameter int AW = 5
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [AW-2:0] strap_addr,
  input  logic          strap_split,
  input  logic [AW-1:0] req_phy,
  output mode_e         mode,
  output logic [AW-1:0] own_phy,
  output logic          fwd_hit,
  output logic [AW-1:0] fwd_dev
);
  mode_e         mode_q;
  logic [AW-2:0] strap_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      strap_q <= strap_addr;
      if (strap_split)          mode_q <= MODE_HALF;
      else if (strap_addr == '0) mode_q <= MODE_FLAT;
      else                      mode_q <= MODE_WIN;
    end
  end

  assign mode    = mode_q;
  assign own_phy = {strap_q, 1'b0};

  always_comb begin
    fwd_hit = 1'b0;
    fwd_dev = req_phy;
    case (mode_q)
      MODE_FLAT: fwd_hit = 1'b1;
      MODE_HALF: begin
        fwd_hit = (req_phy[AW-1] == strap_q[AW-2]);
        fwd_dev = {1'b0, req_phy[AW-2:0]};
      end
      default: fwd_hit = 1'b0;
    endcase
  end

  // R2: mode is frozen once reset is released
  a_r2_mode_frozen: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> $stable(mode_q));
endmodule

// File: rtl/smi_direct_fwd.sv
module smi_direct_fwd #(
  parameter int AW = 5,
  parameter int DW = 16
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          en,
  input  logic          req_valid,
  input  logic          req_write,
  input  logic          hit,
  input  logic [AW-1:0] dev,
  input  logic [AW-1:0] req_reg,
  input  logic [DW-1:0] req_wdata,
  input  logic          ib_ack,
  input  logic [DW-1:0] ib_rdata,
  output logic          ib_req,
  output logic          ib_write,
  output logic [AW-1:0] ib_dev,
  output logic [AW-1:0] ib_reg,
  output logic [DW-1:0] ib_wdata,
  output logic          rsp_valid,
  output logic [DW-1:0] rsp_rdata
);
  logic          req_q, wr_q, rsp_q;
  logic [AW-1:0] dev_q, reg_q;
  logic [DW-1:0] wd_q, rd_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      req_q <= 1'b0;
      wr_q  <= 1'b0;
      rsp_q <= 1'b0;
      dev_q <= '0;
      reg_q <= '0;
      wd_q  <= '0;
      rd_q  <= '0;
    end else begin
      rsp_q <= 1'b0;
      if (req_q) begin
        if (ib_ack) begin
          req_q <= 1'b0;
          rsp_q <= 1'b1;
          rd_q  <= wr_q ? '0 : ib_rdata;
        end
      end else if (en && req_valid) begin
        if (hit) begin
          req_q <= 1'b1;
          wr_q  <= req_write;
          dev_q <= dev;
          reg_q <= req_reg;
          wd_q  <= req_wdata;
        end else begin
          rsp_q <= 1'b1;
          rd_q  <= req_write ? '0 : '1;
        end
      end
    end
  end

  assign ib_req    = req_q;
  assign ib_write  = wr_q;
  assign ib_dev    = dev_q;
  assign ib_reg    = reg_q;
  assign ib_wdata  = wd_q;
  assign rsp_valid = rsp_q;
  assign rsp_rdata = rd_q;

  // R13: forwarded request held steady until acknowledged
  a_r13_fwd_hold: assert property (@(posedge clk) disable iff (rst)
    req_q && !ib_ack |=> req_q && $stable(dev_q) && $stable(reg_q)
                         && $stable(wd_q) && $stable(wr_q));
  // R12: completion pulse is one cycle wide while idle
  a_r12_fwd_pulse: assert property (@(posedge clk) disable iff (rst)
    rsp_q |=> !rsp_q);
endmodule

// File: rtl/smi_indirect_win.sv
module smi_indirect_win
  import smi_win_pkg::*;
#(
  parameter int AW = 5,
  parameter int DW = 16
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          en,
  input  logic          req_valid,
  input  logic          req_write,
  input  logic [AW-1:0] req_phy,
  input  logic [AW-1:0] req_reg,
  input  logic [DW-1:0] req_wdata,
  input  logic [AW-1:0] own_phy,
  input  logic          ib_ack,
  input  logic [DW-1:0] ib_rdata,
  output logic          ib_req,
  output logic          ib_write,
  output logic [AW-1:0] ib_dev,
  output logic [AW-1:0] ib_reg,
  output logic [DW-1:0] ib_wdata,
  output logic          rsp_valid,
  output logic [DW-1:0] rsp_rdata
);
  localparam logic [AW-1:0] REG_CMD  = AW'(0);
  localparam logic [AW-1:0] REG_DATA = AW'(1);

  logic          busy_q, opwr_q, rsp_q;
  logic [AW-1:0] dev_q, reg_q;
  logic [DW-1:0] data_q, rd_q;

  logic          win_hit, is_cmd, go, legal;
  logic [1:0]    opc;
  logic [DW-1:0] cmd_view;

  assign is_cmd  = (req_reg == REG_CMD);
  assign win_hit = (req_phy == own_phy) && (is_cmd || req_reg == REG_DATA);
  assign opc     = req_wdata[CMD_OP_LO +: 2];
  assign go      = req_wdata[CMD_GO_BIT];
  assign legal   = req_wdata[CMD_FMT_BIT] && (opc == OP_WRITE || opc == OP_READ);

  always_comb begin
    cmd_view = '0;
    cmd_view[CMD_GO_BIT] = busy_q;
    cmd_view[CMD_DEV_LO +: AW] = dev_q;
    cmd_view[CMD_REG_LO +: AW] = reg_q;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      busy_q <= 1'b0;
      opwr_q <= 1'b0;
      rsp_q  <= 1'b0;
      dev_q  <= '0;
      reg_q  <= '0;
      data_q <= '0;
      rd_q   <= '0;
    end else begin
      rsp_q <= 1'b0;
      if (busy_q && ib_ack) begin
        busy_q <= 1'b0;
        if (!opwr_q) data_q <= ib_rdata;
      end
      if (en && req_valid) begin
        rsp_q <= 1'b1;
        if (!win_hit) begin
          rd_q <= req_write ? '0 : '1;
        end else if (!req_write) begin
          rd_q <= is_cmd ? cmd_view : data_q;
        end else begin
          rd_q <= '0;
          if (!busy_q) begin
            if (is_cmd) begin
              dev_q <= req_wdata[CMD_DEV_LO +: AW];
              reg_q <= req_wdata[CMD_REG_LO +: AW];
              if (go && legal) begin
                busy_q <= 1'b1;
                opwr_q <= (opc == OP_WRITE);
              end
            end else begin
              data_q <= req_wdata;
            end
          end
        end
      end
    end
  end

  assign ib_req    = busy_q;
  assign ib_write  = opwr_q;
  assign ib_dev    = dev_q;
  assign ib_reg    = reg_q;
  assign ib_wdata  = data_q;
  assign rsp_valid = rsp_q;
  assign rsp_rdata = rd_q;

  // R8: acknowledge ends the pending operation at that edge
  a_r8_busy_clears: assert property (@(posedge clk) disable iff (rst)
    busy_q && ib_ack |=> !busy_q);
  // R10: window registers frozen while an operation is pending
  a_r10_hold_busy: assert property (@(posedge clk) disable iff (rst)
    busy_q && !ib_ack |=> busy_q && $stable(dev_q) && $stable(reg_q)
                          && $stable(data_q) && $stable(opwr_q));
  // R5: unowned reads float high
  a_r5_miss_ones: assert property (@(posedge clk) disable iff (rst)
    en && req_valid && !req_write && !win_hit |=> rsp_q && (rd_q == '1));
  // R9: malformed command never starts an access
  a_r9_no_launch: assert property (@(posedge clk) disable iff (rst)
    en && req_valid && req_write && win_hit && is_cmd && !busy_q
      && !(go && legal) |=> !busy_q);
endmodule

// File: rtl/smi_window_bridge.sv
module smi_window_bridge
  import smi_win_pkg::*;
#(
  parameter int AW = 5,
  parameter int DW = 16
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [AW-2:0] strap_addr,
  input  logic          strap_split,
  input  logic          req_valid,
  input  logic          req_write,
  input  logic [AW-1:0] req_phy,
  input  logic [AW-1:0] req_reg,
  input  logic [DW-1:0] req_wdata,
  output logic          rsp_valid,
  output logic [DW-1:0] rsp_rdata,
  output logic          ib_req,
  output logic          ib_write,
  output logic [AW-1:0] ib_dev,
  output logic [AW-1:0] ib_reg,
  output logic [DW-1:0] ib_wdata,
  input  logic          ib_ack,
  input  logic [DW-1:0] ib_rdata
);
  mode_e         mode;
  logic [AW-1:0] own_phy, fwd_dev;
  logic          fwd_hit, win_en, fwd_en;

  logic          d_req, d_wr, d_rsp, w_req, w_wr, w_rsp;
  logic [AW-1:0] d_dev, d_reg, w_dev, w_reg;
  logic [DW-1:0] d_wd, d_rd, w_wd, w_rd;

  smi_strap_decode #(.AW(AW)) u_dec (
    .clk(clk), .rst(rst), .strap_addr(strap_addr), .strap_split(strap_split),
    .req_phy(req_phy), .mode(mode), .own_phy(own_phy),
    .fwd_hit(fwd_hit), .fwd_dev(fwd_dev)
  );

  assign win_en = (mode == MODE_WIN);
  assign fwd_en = !win_en;

  smi_direct_fwd #(.AW(AW), .DW(DW)) u_fwd (
    .clk(clk), .rst(rst), .en(fwd_en), .req_valid(req_valid),
    .req_write(req_write), .hit(fwd_hit), .dev(fwd_dev), .req_reg(req_reg),
    .req_wdata(req_wdata), .ib_ack(ib_ack && fwd_en), .ib_rdata(ib_rdata),
    .ib_req(d_req), .ib_write(d_wr), .ib_dev(d_dev), .ib_reg(d_reg),
    .ib_wdata(d_wd), .rsp_valid(d_rsp), .rsp_rdata(d_rd)
  );

  smi_indirect_win #(.AW(AW), .DW(DW)) u_win (
    .clk(clk), .rst(rst), .en(win_en), .req_valid(req_valid),
    .req_write(req_write), .req_phy(req_phy), .req_reg(req_reg),
    .req_wdata(req_wdata), .own_phy(own_phy),
    .ib_ack(ib_ack && win_en), .ib_rdata(ib_rdata),
    .ib_req(w_req), .ib_write(w_wr), .ib_dev(w_dev), .ib_reg(w_reg),
    .ib_wdata(w_wd), .rsp_valid(w_rsp), .rsp_rdata(w_rd)
  );

  assign ib_req    = win_en ? w_req : d_req;
  assign ib_write  = win_en ? w_wr  : d_wr;
  assign ib_dev    = win_en ? w_dev : d_dev;
  assign ib_reg    = win_en ? w_reg : d_reg;
  assign ib_wdata  = win_en ? w_wd  : d_wd;
  assign rsp_valid = d_rsp | w_rsp;
  assign rsp_rdata = w_rsp ? w_rd : d_rd;

  // R12: only one engine ever answers
  a_r12_one_source: assert property (@(posedge clk) disable iff (rst)
    $onehot0({d_rsp, w_rsp}));
  // R13: the idle engine never requests the internal port
  a_r13_idle_quiet: assert property (@(posedge clk) disable iff (rst)
    win_en ? !d_req : !w_req);
endmodule

// File: tb/tb_smi_window_bridge.sv
module tb_smi_window_bridge;
  localparam int AW = 5;
  localparam int DW = 16;
  localparam int K_WR = 0, K_RD = 1, K_POLL = 2;

  typedef struct packed {
    logic [1:0]  kind;
    logic [3:0]  rq;
    logic [4:0]  phy;
    logic [4:0]  rg;
    logic [15:0] wd;
    logic [15:0] exp;
  } vec_t;

  localparam int NV = 18;
  // windowed mode, own address 6
  localparam vec_t VECS [NV] = '{
    '{2'd0, 4'd7,  5'd6, 5'd1, 16'h1234, 16'h0000}, // R7 load data
    '{2'd0, 4'd6,  5'd6, 5'd0, 16'h9467, 16'h0000}, // R6 write dev3 reg7
    '{2'd2, 4'd6,  5'd6, 5'd0, 16'h0000, 16'h0000},
    '{2'd1, 4'd11, 5'd6, 5'd0, 16'h0000, 16'h0067}, // R11 view
    '{2'd0, 4'd6,  5'd6, 5'd0, 16'h98A2, 16'h0000}, // R6 read dev5 reg2
    '{2'd2, 4'd8,  5'd6, 5'd0, 16'h0000, 16'h0000},
    '{2'd1, 4'd8,  5'd6, 5'd1, 16'h0000, 16'h28AA}, // R8 result
    '{2'd0, 4'd6,  5'd6, 5'd0, 16'h9867, 16'h0000},
    '{2'd2, 4'd8,  5'd6, 5'd0, 16'h0000, 16'h0000},
    '{2'd1, 4'd7,  5'd6, 5'd1, 16'h0000, 16'h1234}, // R7 readback
    '{2'd0, 4'd9,  5'd6, 5'd0, 16'h9C21, 16'h0000}, // R9 opcode 11
    '{2'd1, 4'd9,  5'd6, 5'd0, 16'h0000, 16'h0021},
    '{2'd1, 4'd9,  5'd6, 5'd1, 16'h0000, 16'h1234},
    '{2'd0, 4'd9,  5'd6, 5'd0, 16'h8867, 16'h0000}, // R9 format bit 0
    '{2'd1, 4'd9,  5'd6, 5'd0, 16'h0000, 16'h0067},
    '{2'd1, 4'd5,  5'd7, 5'd0, 16'h0000, 16'hFFFF}, // R5 other address
    '{2'd1, 4'd5,  5'd6, 5'd2, 16'h0000, 16'hFFFF}, // R5 other register
    '{2'd1, 4'd5,  5'd4, 5'd1, 16'h0000, 16'hFFFF}  // R5 other address
  };

  logic          clk = 1'b0, rst = 1'b1;
  logic [AW-2:0] strap_addr = '0;
  logic          strap_split = 1'b0;
  logic          req_valid = 1'b0, req_write = 1'b0;
  logic [AW-1:0] req_phy = '0, req_reg = '0;
  logic [DW-1:0] req_wdata = '0;
  logic          rsp_valid;
  logic [DW-1:0] rsp_rdata;
  logic          ib_req, ib_write;
  logic [AW-1:0] ib_dev, ib_reg;
  logic [DW-1:0] ib_wdata;
  logic          ib_ack = 1'b0;
  logic [DW-1:0] ib_rdata = '0;

  smi_window_bridge #(.AW(AW), .DW(DW)) dut (
    .clk(clk), .rst(rst), .strap_addr(strap_addr), .strap_split(strap_split),
    .req_valid(req_valid), .req_write(req_write), .req_phy(req_phy),
    .req_reg(req_reg), .req_wdata(req_wdata), .rsp_valid(rsp_valid),
    .rsp_rdata(rsp_rdata), .ib_req(ib_req), .ib_write(ib_write),
    .ib_dev(ib_dev), .ib_reg(ib_reg), .ib_wdata(ib_wdata),
    .ib_ack(ib_ack), .ib_rdata(ib_rdata)
  );

  always #4 clk = ~clk;

  int n_chk = 0, n_bad = 0, acc_cnt = 0, lat = 2, waitc = 0;
  bit auto_ack = 1'b1, done = 1'b0;
  logic [4:0]  last_dev;
  logic [15:0] mem [32][32];

  function automatic logic [15:0] pattern(input int d, input int r);
    return {d[4:0], r[4:0], 6'h2A};
  endfunction

  task automatic check(input string tag, input logic [15:0] act, input logic [15:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic summary();
    if (!done) begin
      done = 1'b1;
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  endtask

  // internal port responder
  initial forever begin
    @(negedge clk);
    if (auto_ack) begin
      if (ib_ack) ib_ack = 1'b0;
      else if (ib_req) begin
        if (waitc < lat) waitc++;
        else begin
          waitc = 0;
          ib_ack = 1'b1;
          acc_cnt++;
          last_dev = ib_dev;
          if (ib_write) begin
            mem[ib_dev][ib_reg] = ib_wdata;
            ib_rdata = '0;
          end else ib_rdata = mem[ib_dev][ib_reg];
        end
      end
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog actual=hung expected=finish");
    summary();
  end

  task automatic do_reset(input logic [3:0] s, input logic sp);
    strap_addr = s; strap_split = sp; rst = 1'b1;
    repeat (3) @(negedge clk);
    rst = 1'b0;
  endtask

  task automatic xfer(input logic w, input logic [4:0] p, input logic [4:0] g,
                      input logic [15:0] d, output logic [15:0] rd, output int waited);
    req_valid = 1'b1; req_write = w; req_phy = p; req_reg = g; req_wdata = d;
    @(negedge clk);
    req_valid = 1'b0;
    waited = 0;
    while (!rsp_valid && waited < 1000) begin
      @(negedge clk);
      waited++;
    end
    rd = rsp_rdata;
    @(negedge clk);
  endtask

  logic [15:0] rd;
  int w, a0;

  initial begin
    for (int d = 0; d < 32; d++)
      for (int r = 0; r < 32; r++) mem[d][r] = pattern(d, r);

    // windowed mode, address 6
    do_reset(4'h3, 1'b0);
    check("R1 rsp_valid after reset", {15'd0, rsp_valid}, 16'd0);
    check("R1 ib_req after reset", {15'd0, ib_req}, 16'd0);
    xfer(1'b0, 5'd6, 5'd0, 16'h0, rd, w);
    check("R1 command after reset", rd, 16'h0000);
    check("R12 window answer next cycle", w[15:0], 16'd0);
    check("R12 pulse one cycle", {15'd0, rsp_valid}, 16'd0);
    xfer(1'b0, 5'd6, 5'd1, 16'h0, rd, w);
    check("R1 data after reset", rd, 16'h0000);

    for (int i = 0; i < NV; i++) begin
      if (VECS[i].kind == 2'(K_WR)) begin
        xfer(1'b1, VECS[i].phy, VECS[i].rg, VECS[i].wd, rd, w);
      end else if (VECS[i].kind == 2'(K_RD)) begin
        xfer(1'b0, VECS[i].phy, VECS[i].rg, 16'h0, rd, w);
        check($sformatf("R%0d vector %0d", VECS[i].rq, i), rd, VECS[i].exp);
      end else begin
        int polls = 0;
        do begin
          xfer(1'b0, VECS[i].phy, 5'd0, 16'h0, rd, w);
          polls++;
        end while (rd[15] && polls < 60);
        check($sformatf("R%0d busy clears vector %0d", VECS[i].rq, i), {15'd0, rd[15]}, 16'd0);
      end
    end
    check("R7 internal write landed", mem[3][7], 16'h1234);

    // R9: malformed commands make no access
    a0 = acc_cnt;
    xfer(1'b1, 5'd6, 5'd0, 16'h9C21, rd, w);
    xfer(1'b1, 5'd6, 5'd0, 16'h0867, rd, w);
    xfer(1'b1, 5'd6, 5'd0, 16'h8867, rd, w);
    repeat (6) @(negedge clk);
    check("R9 no internal access", 16'(acc_cnt - a0), 16'd0);
    xfer(1'b0, 5'd6, 5'd0, 16'h0, rd, w);
    check("R9 fields stored, busy 0", rd, 16'h0067);

    // R10: writes ignored while busy
    lat = 20;
    xfer(1'b1, 5'd6, 5'd0, 16'h98A2, rd, w);
    xfer(1'b1, 5'd6, 5'd0, 16'h9467, rd, w);
    xfer(1'b1, 5'd6, 5'd1, 16'h5555, rd, w);
    xfer(1'b0, 5'd6, 5'd0, 16'h0, rd, w);
    check("R10 R11 busy view keeps first command", rd, 16'h80A2);
    repeat (30) @(negedge clk);
    xfer(1'b0, 5'd6, 5'd1, 16'h0, rd, w);
    check("R10 data write dropped while busy", rd, 16'h28AA);
    check("R10 second command not run", mem[3][7], 16'h1234);
    lat = 2;

    // R11/R8: command read in the acknowledge cycle
    auto_ack = 1'b0;
    xfer(1'b1, 5'd6, 5'd0, 16'h9841, rd, w);
    repeat (4) @(negedge clk);
    check("R13 request held without ack", {ib_req, 10'd0, ib_dev}, 16'h8002);
    ib_ack = 1'b1; ib_rdata = 16'hC0DE;
    req_valid = 1'b1; req_write = 1'b0; req_phy = 5'd6; req_reg = 5'd0;
    @(negedge clk);
    ib_ack = 1'b0; req_valid = 1'b0;
    check("R11 same-cycle read sees busy", rsp_rdata, 16'h8041);
    @(negedge clk);
    xfer(1'b0, 5'd6, 5'd1, 16'h0, rd, w);
    check("R8 data captured on ack", rd, 16'hC0DE);
    xfer(1'b0, 5'd6, 5'd0, 16'h0, rd, w);
    check("R8 busy cleared on ack", rd, 16'h0041);

    // R10: command write in the acknowledge cycle is dropped
    xfer(1'b1, 5'd6, 5'd0, 16'h9467, rd, w);
    @(negedge clk);
    check("R7 write presents data register", {ib_write, ib_wdata[14:0]}, {1'b1, 15'h40DE});
    ib_ack = 1'b1;
    req_valid = 1'b1; req_write = 1'b1; req_phy = 5'd6; req_reg = 5'd0; req_wdata = 16'h9862;
    @(negedge clk);
    ib_ack = 1'b0; req_valid = 1'b0;
    @(negedge clk);
    xfer(1'b0, 5'd6, 5'd0, 16'h0, rd, w);
    check("R10 colliding command dropped", rd, 16'h0067);
    check("R10 no new request", {15'd0, ib_req}, 16'd0);
    auto_ack = 1'b1;

    // flat mode
    do_reset(4'h0, 1'b0);
    lat = 1;
    strap_addr = 4'h3;
    xfer(1'b1, 5'd9, 5'd4, 16'hBEEF, rd, w);
    check("R3 flat write forwarded", mem[9][4], 16'hBEEF);
    xfer(1'b0, 5'd31, 5'd31, 16'h0, rd, w);
    check("R3 flat read", rd, pattern(31, 31));
    xfer(1'b0, 5'd6, 5'd0, 16'h0, rd, w);
    check("R2 straps frozen after reset", rd, pattern(6, 0));

    // half-space mode, upper half
    do_reset(4'b1000, 1'b1);
    xfer(1'b0, 5'd18, 5'd3, 16'h0, rd, w);
    check("R4 upper half read", rd, pattern(2, 3));
    check("R4 device offset", {11'd0, last_dev}, 16'd2);
    a0 = acc_cnt;
    xfer(1'b0, 5'd5, 5'd3, 16'h0, rd, w);
    check("R4 foreign half floats", rd, 16'hFFFF);
    check("R4 foreign half no access", 16'(acc_cnt - a0), 16'd0);
    xfer(1'b1, 5'd17, 5'd0, 16'hA5A5, rd, w);
    check("R4 upper half write", mem[1][0], 16'hA5A5);

    // half-space mode, lower half
    do_reset(4'b0110, 1'b1);
    xfer(1'b0, 5'd3, 5'd1, 16'h0, rd, w);
    check("R2 R4 lower half read", rd, pattern(3, 1));
    xfer(1'b0, 5'd19, 5'd1, 16'h0, rd, w);
    check("R4 upper half not owned", rd, 16'hFFFF);

    summary();
  end
endmodule